// File: doc/BRIEF.md
# Owner-Pointer Prediction Table

This block is a small set-associative table kept next to each core's private data cache. It holds, for each recently seen block address, a guess of the tile that currently owns that block. When the private cache misses, the miss logic presents the block address on the lookup port. Two cycles later the table answers. On a hit, the miss request can go straight to the predicted owner tile. On a miss, the request goes to the home slice of the shared cache, which holds the authoritative owner record.

The table learns from two update sources. The first is the invalidate-update port. When the local copy of a block is invalidated, the identity of the tile whose request caused the invalidation is recorded as the new owner guess. The second is the hint-update port. An optional ownership-change message overwrites the guess with the announced new owner. Each set is four ways. Empty ways are filled before anything is evicted, and a tree pseudo-LRU chooses the victim once a set is full. Only table updates move the pseudo-LRU state.

Top module: `opc_owner_predictor`

## Requirements
- R1: After reset, no entry is valid, `rsp_valid` and `rsp_hit` are low, and every lookup misses.
- R2: A lookup presented with `lk_valid` high in cycle n produces its response in cycle n+2. `rsp_valid` is high for exactly that one cycle per request.
- R3: A lookup hit drives `rsp_hit`=1 and `rsp_owner` equal to the stored owner tile. A lookup miss drives `rsp_hit`=0 and `rsp_owner`=0, which sends the request to the home slice.
- R4: An invalidate-update writes `inv_requester` as the owner of `inv_addr`. If the address is not already present, an entry is allocated for it.
- R5: A hint-update writes `hint_owner` as the owner of `hint_addr`. If the address is not already present, an entry is allocated for it.
- R6: An update to an address that is already present rewrites that entry in place. No other way of the set changes.
- R7: The block address splits into a set index (low SET_W bits, 7 by default) and a tag (the remaining bits). A fill goes into the lowest-numbered invalid way. When the set is full, a 3-bit tree chooses the victim. The root bit picks the half: 0 selects ways 0–1 and 1 selects ways 2–3. The left leaf bit picks way 1 when set, otherwise way 0. The right leaf bit picks way 3 when set, otherwise way 2. A write to a way sets the bits on its path so that they point away from that way. All bits are 0 after reset.
- R8: Lookups never change the replacement state. Only update writes (in-place rewrites and fills) do.
- R9: When an invalidate-update and a hint-update fall in the same set in the same cycle, only the hint-update takes effect. The invalidate-update is dropped. Updates to different sets in the same cycle both take effect.
- R10: A lookup in the same cycle as an update to the same address returns the table contents from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | 1 | Lookup request strobe |
| lk_addr | input | ADDR_W | Block address to look up |
| rsp_valid | output | 1 | Lookup response strobe, two cycles after the request |
| rsp_hit | output | 1 | Predicted owner found |
| rsp_owner | output | OWNER_W | Predicted owner tile (0 on a miss) |
| inv_valid | input | 1 | Local copy was invalidated |
| inv_addr | input | ADDR_W | Block address of the invalidated copy |
| inv_requester | input | OWNER_W | Tile whose request caused the invalidation |
| hint_valid | input | 1 | Ownership-change hint strobe |
| hint_addr | input | ADDR_W | Block address named by the hint |
| hint_owner | input | OWNER_W | New owner tile named by the hint |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the two update ports. The bench drives an invalidate-update and a hint-update together in one cycle, in three cases: to the same set with different tags, to the same address, and to different sets. It judges each case by later lookups. In the same-set cases only the hint's address and owner may be found. In the different-set case both must be found. The second pair is a lookup and an update. The bench presents a lookup in the same cycle as an update of the same address, for both an address already present and one not yet present. It expects the pre-update answer from that lookup and the new value from the next one.

// File: rtl/opc_pkg.sv
package opc_pkg;
  // update source index inside the table
  localparam int UPD_INV  = 0;
  localparam int UPD_HINT = 1;
  localparam int UPD_NUM  = 2;
endpackage

// File: rtl/opc_way_pick.sv
module opc_way_pick #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 13,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]            row_vld,
  input  logic [WAYS-1:0][TAG_W-1:0] row_tag,
  input  logic [TAG_W-1:0]           tag,
  output logic                       hit,
  output logic [WAY_W-1:0]           hit_way,
  output logic                       has_free,
  output logic [WAY_W-1:0]           free_way
);
  // descending scan so the lowest matching way is the one kept
  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    has_free = 1'b0;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (row_vld[w] && (row_tag[w] == tag)) begin
        hit     = 1'b1;
        hit_way = WAY_W'(w);
      end
      if (!row_vld[w]) begin
        has_free = 1'b1;
        free_way = WAY_W'(w);
      end
    end
  end
endmodule

// File: rtl/opc_plru_tree.sv
module opc_plru_tree #(
  parameter int WAYS = 4,
  localparam int WAY_W = $clog2(WAYS),
  localparam int LVL   = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  state,
  input  logic [WAY_W-1:0] touch_way,
  output logic [WAY_W-1:0] victim,
  output logic [WAYS-2:0]  state_nxt
);
  // node 0 is the root, children of n are 2n+1 and 2n+2, leaves map to ways
  always_comb begin
    int node;
    node = 0;
    for (int l = 0; l < LVL; l++) begin
      node = 2 * node + 1 + (state[node] ? 1 : 0);
    end
    victim = WAY_W'(node - (WAYS - 1));
  end

  always_comb begin
    int node;
    int parent;
    state_nxt = state;
    node      = int'(touch_way) + WAYS - 1;
    for (int l = 0; l < LVL; l++) begin
      parent            = (node - 1) / 2;
      state_nxt[parent] = (node == 2 * parent + 1);
      node              = parent;
    end
  end
endmodule

// File: rtl/opc_lookup_pipe.sv
module opc_lookup_pipe #(
  parameter int WAYS    = 4,
  parameter int TAG_W   = 13,
  parameter int OWNER_W = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req,
  input  logic [TAG_W-1:0]             req_tag,
  input  logic [WAYS-1:0]              row_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]   row_tag,
  input  logic [WAYS-1:0][OWNER_W-1:0] row_own,
  output logic                         rsp_valid,
  output logic                         rsp_hit,
  output logic [OWNER_W-1:0]           rsp_owner
);
  // stage 1: capture the set row as it stands before any same-cycle write
  logic                         s1_req;
  logic [TAG_W-1:0]             s1_tag;
  logic [WAYS-1:0]              s1_vld;
  logic [WAYS-1:0][TAG_W-1:0]   s1_row_tag;
  logic [WAYS-1:0][OWNER_W-1:0] s1_row_own;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_req <= 1'b0;
      s1_vld <= '0;
    end else begin
      s1_req <= req;
      if (req) s1_vld <= row_vld;
    end
  end

  always_ff @(posedge clk) begin
    if (req) begin
      s1_tag     <= req_tag;
      s1_row_tag <= row_tag;
      s1_row_own <= row_own;
    end
  end

  // stage 2: compare and register the answer
  logic             cmp_hit;
  logic [WAY_W-1:0] cmp_way;
  logic             cmp_free_unused;
  logic [WAY_W-1:0] cmp_free_way_unused;

  opc_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_cmp (
    .row_vld  (s1_vld),
    .row_tag  (s1_row_tag),
    .tag      (s1_tag),
    .hit      (cmp_hit),
    .hit_way  (cmp_way),
    .has_free (cmp_free_unused),
    .free_way (cmp_free_way_unused)
  );

  logic               hit_d;
  logic [OWNER_W-1:0] own_d;

  always_comb begin
    hit_d = s1_req && cmp_hit;
    own_d = hit_d ? s1_row_own[cmp_way] : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_owner <= '0;
    end else begin
      rsp_valid <= s1_req;
      rsp_hit   <= hit_d;
      rsp_owner <= own_d;
    end
  end
endmodule

// File: rtl/opc_owner_predictor.sv
module opc_owner_predictor #(
  parameter int ADDR_W  = 20,
  parameter int SETS    = 128,
  parameter int WAYS    = 4,
  parameter int OWNER_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_valid,
  input  logic [ADDR_W-1:0]  lk_addr,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [OWNER_W-1:0] rsp_owner,
  input  logic               inv_valid,
  input  logic [ADDR_W-1:0]  inv_addr,
  input  logic [OWNER_W-1:0] inv_requester,
  input  logic               hint_valid,
  input  logic [ADDR_W-1:0]  hint_addr,
  input  logic [OWNER_W-1:0] hint_owner
);
  import opc_pkg::*;

  localparam int SET_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - SET_W;
  localparam int WAY_W = $clog2(WAYS);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // table storage
  logic [WAYS-1:0]              vld_q [SETS];
  logic [WAYS-1:0][TAG_W-1:0]   tag_q [SETS];
  logic [WAYS-1:0][OWNER_W-1:0] own_q [SETS];
  logic [WAYS-2:0]              plru_q[SETS];

  // update ports gathered into arrays
  logic               upd_v   [UPD_NUM];
  logic [ADDR_W-1:0]  upd_a   [UPD_NUM];
  logic [OWNER_W-1:0] upd_id  [UPD_NUM];
  logic [SET_W-1:0]   upd_set [UPD_NUM];
  logic [TAG_W-1:0]   upd_tag [UPD_NUM];
  logic               upd_we  [UPD_NUM];
  logic [WAY_W-1:0]   upd_way [UPD_NUM];
  logic [WAYS-2:0]    upd_plru[UPD_NUM];

  assign upd_v[UPD_INV]   = inv_valid;
  assign upd_a[UPD_INV]   = inv_addr;
  assign upd_id[UPD_INV]  = inv_requester;
  assign upd_v[UPD_HINT]  = hint_valid;
  assign upd_a[UPD_HINT]  = hint_addr;
  assign upd_id[UPD_HINT] = hint_owner;

  // hint wins a same-set conflict
  logic same_set;
  assign same_set = (upd_set[UPD_INV] == upd_set[UPD_HINT]);
  assign upd_we[UPD_INV]  = upd_v[UPD_INV] && !(upd_v[UPD_HINT] && same_set);
  assign upd_we[UPD_HINT] = upd_v[UPD_HINT];

  for (genvar p = 0; p < UPD_NUM; p++) begin : g_upd
    logic             hit;
    logic [WAY_W-1:0] hit_way;
    logic             has_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] victim;

    assign upd_set[p] = upd_a[p][SET_W-1:0];
    assign upd_tag[p] = upd_a[p][ADDR_W-1:SET_W];

    opc_way_pick #(.WAYS(WAYS), .TAG_W(TAG_W)) u_pick (
      .row_vld  (vld_q[upd_set[p]]),
      .row_tag  (tag_q[upd_set[p]]),
      .tag      (upd_tag[p]),
      .hit      (hit),
      .hit_way  (hit_way),
      .has_free (has_free),
      .free_way (free_way)
    );

    // victim comes from the current state; next state is computed for the chosen way
    opc_plru_tree #(.WAYS(WAYS)) u_plru (
      .state     (plru_q[upd_set[p]]),
      .touch_way (upd_way[p]),
      .victim    (victim),
      .state_nxt (upd_plru[p])
    );

    always_comb begin
      if (hit)           upd_way[p] = hit_way;
      else if (has_free) upd_way[p] = free_way;
      else               upd_way[p] = victim;
    end
  end

  // valid bits and replacement state
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s]  <= '0;
        plru_q[s] <= '0;
      end
    end else begin
      for (int p = 0; p < UPD_NUM; p++) begin
        if (upd_we[p]) begin
          vld_q[upd_set[p]][upd_way[p]] <= 1'b1;
          plru_q[upd_set[p]]            <= upd_plru[p];
        end
      end
    end
  end

  // tags and owners, write-enabled, no reset
  always_ff @(posedge clk) begin
    for (int p = 0; p < UPD_NUM; p++) begin
      if (upd_we[p]) begin
        tag_q[upd_set[p]][upd_way[p]] <= upd_tag[p];
        own_q[upd_set[p]][upd_way[p]] <= upd_id[p];
      end
    end
  end

  // lookup path
  logic [SET_W-1:0] lk_set;
  assign lk_set = lk_addr[SET_W-1:0];

  opc_lookup_pipe #(.WAYS(WAYS), .TAG_W(TAG_W), .OWNER_W(OWNER_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .req       (lk_valid),
    .req_tag   (lk_addr[ADDR_W-1:SET_W]),
    .row_vld   (vld_q[lk_set]),
    .row_tag   (tag_q[lk_set]),
    .row_own   (own_q[lk_set]),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_owner (rsp_owner)
  );
endmodule

// File: rtl/opc_owner_predictor_chk.sv
module opc_owner_predictor_chk #(
  parameter int ADDR_W  = 20,
  parameter int OWNER_W = 4,
  parameter int SET_W   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_valid,
  input logic [ADDR_W-1:0]  lk_addr,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic [OWNER_W-1:0] rsp_owner,
  input logic               inv_valid,
  input logic [ADDR_W-1:0]  inv_addr,
  input logic [OWNER_W-1:0] inv_requester,
  input logic               hint_valid,
  input logic [ADDR_W-1:0]  hint_addr,
  input logic [OWNER_W-1:0] hint_owner
);
  // cycles since reset release, saturating, guards the $past look-back
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_rst <= 2'd0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R2
  lat_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> ##1 rsp_valid);

  // R2
  lat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> ##1 !rsp_valid);

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (rsp_owner == '0));

  // R1
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (!rsp_hit && rsp_owner == '0));

  // R5
  hint_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(hint_valid, 3) && $past(lk_valid, 2) &&
     $past(lk_addr, 2) == $past(hint_addr, 3))
    |-> (rsp_hit && rsp_owner == $past(hint_owner, 3)));

  // R4, R9
  inv_learn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd3 && $past(inv_valid, 3) && $past(lk_valid, 2) &&
     $past(lk_addr, 2) == $past(inv_addr, 3) &&
     !($past(hint_valid, 3) &&
       $past(hint_addr[SET_W-1:0], 3) == $past(inv_addr[SET_W-1:0], 3)))
    |-> (rsp_hit && rsp_owner == $past(inv_requester, 3)));
endmodule

bind opc_owner_predictor opc_owner_predictor_chk #(
  .ADDR_W(ADDR_W), .OWNER_W(OWNER_W), .SET_W($clog2(SETS))
) u_chk (
  .clk           (clk),
  .rst_n         (rst_int_n),
  .lk_valid      (lk_valid),
  .lk_addr       (lk_addr),
  .rsp_valid     (rsp_valid),
  .rsp_hit       (rsp_hit),
  .rsp_owner     (rsp_owner),
  .inv_valid     (inv_valid),
  .inv_addr      (inv_addr),
  .inv_requester (inv_requester),
  .hint_valid    (hint_valid),
  .hint_addr     (hint_addr),
  .hint_owner    (hint_owner)
);

// File: tb/opc_owner_predictor_bench.sv
module opc_owner_predictor_bench;
  localparam int ADDR_W  = 20;
  localparam int SET_W   = 7;
  localparam int OWNER_W = 4;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               lk_valid = 1'b0;
  logic [ADDR_W-1:0]  lk_addr = '0;
  logic               rsp_valid;
  logic               rsp_hit;
  logic [OWNER_W-1:0] rsp_owner;
  logic               inv_valid = 1'b0;
  logic [ADDR_W-1:0]  inv_addr = '0;
  logic [OWNER_W-1:0] inv_requester = '0;
  logic               hint_valid = 1'b0;
  logic [ADDR_W-1:0]  hint_addr = '0;
  logic [OWNER_W-1:0] hint_owner = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2ns clk = ~clk;

  opc_owner_predictor u_opc_owner_predictor (
    .clk (clk), .rst_n (rst_n),
    .lk_valid (lk_valid), .lk_addr (lk_addr),
    .rsp_valid (rsp_valid), .rsp_hit (rsp_hit), .rsp_owner (rsp_owner),
    .inv_valid (inv_valid), .inv_addr (inv_addr), .inv_requester (inv_requester),
    .hint_valid (hint_valid), .hint_addr (hint_addr), .hint_owner (hint_owner)
  );

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx);
    return ADDR_W'(tag * (1 << SET_W) + idx);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one cycle of inputs, released after the edge
  task automatic step(input bit lv, input logic [ADDR_W-1:0] la,
                      input bit iv, input logic [ADDR_W-1:0] ia, input int ir,
                      input bit hv, input logic [ADDR_W-1:0] ha, input int ho);
    @(negedge clk);
    lk_valid = lv; lk_addr = la;
    inv_valid = iv; inv_addr = ia; inv_requester = OWNER_W'(ir);
    hint_valid = hv; hint_addr = ha; hint_owner = OWNER_W'(ho);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0; inv_valid = 1'b0; hint_valid = 1'b0;
  endtask

  // after step() with a lookup, the response is visible after the next edge
  task automatic wait_rsp(input string req, input bit eh, input int eo);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b1, req, int'(rsp_valid), 1);
    check(rsp_hit == eh, req, int'(rsp_hit), int'(eh));
    check(rsp_owner == OWNER_W'(eo), req, int'(rsp_owner), eo);
  endtask

  task automatic look(input logic [ADDR_W-1:0] a, input bit eh, input int eo, input string req);
    step(1'b1, a, 1'b0, '0, 0, 1'b0, '0, 0);
    wait_rsp(req, eh, eo);
  endtask

  task automatic inv(input logic [ADDR_W-1:0] a, input int r);
    step(1'b0, '0, 1'b1, a, r, 1'b0, '0, 0);
  endtask

  task automatic hint(input logic [ADDR_W-1:0] a, input int o);
    step(1'b0, '0, 1'b0, '0, 0, 1'b1, a, o);
  endtask

  task automatic t_reset;
    check(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
    check(rsp_hit == 1'b0, "R1 rsp_hit", int'(rsp_hit), 0);
    look(mk(3, 1), 1'b0, 0, "R1 empty lookup");
    look(mk(0, 0), 1'b0, 0, "R1 empty lookup addr0");
  endtask

  task automatic t_latency;
    inv(mk(40, 2), 6);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = mk(40, 2);
    @(posedge clk);
    @(negedge clk);
    lk_valid = 1'b0;
    check(rsp_valid == 1'b0, "R2 not after one edge", int'(rsp_valid), 0);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b1, "R2 valid after two edges", int'(rsp_valid), 1);
    check(rsp_owner == 4'd6, "R2 owner", int'(rsp_owner), 6);
    @(posedge clk);
    @(negedge clk);
    check(rsp_valid == 1'b0, "R2 single cycle", int'(rsp_valid), 0);
  endtask

  task automatic t_basic;
    inv(mk(1, 10), 5);
    look(mk(1, 10), 1'b1, 5, "R4 invalidate learns requester");
    hint(mk(2, 10), 12);
    look(mk(2, 10), 1'b1, 12, "R5 hint learns owner");
    look(mk(9, 10), 1'b0, 0, "R3 absent address misses");
    hint(mk(1, 10), 7);
    look(mk(1, 10), 1'b1, 7, "R6 rewrite in place");
    look(mk(2, 10), 1'b1, 12, "R6 neighbour untouched");
    inv(mk(1, 10), 15);
    look(mk(1, 10), 1'b1, 15, "R4 invalidate overwrites");
  endtask

  // set 5: fills ways 0..3, then tree victim selection
  task automatic t_replace;
    inv(mk(1, 5), 1);
    inv(mk(2, 5), 2);
    inv(mk(3, 5), 3);
    inv(mk(4, 5), 4);
    look(mk(1, 5), 1'b1, 1, "R7 fill way0");
    look(mk(2, 5), 1'b1, 2, "R7 fill way1");
    look(mk(3, 5), 1'b1, 3, "R7 fill way2");
    look(mk(4, 5), 1'b1, 4, "R7 fill way3");
    // repeated lookups of tag 1 must not protect it
    look(mk(1, 5), 1'b1, 1, "R8 lookup tag1");
    look(mk(1, 5), 1'b1, 1, "R8 lookup tag1 again");
    inv(mk(5, 5), 8);
    look(mk(1, 5), 1'b0, 0, "R8 lookups did not move victim");
    look(mk(5, 5), 1'b1, 8, "R7 new fill");
    look(mk(2, 5), 1'b1, 2, "R7 survivor 2");
    look(mk(4, 5), 1'b1, 4, "R7 survivor 4");
    hint(mk(2, 5), 11);
    inv(mk(6, 5), 9);
    look(mk(3, 5), 1'b0, 0, "R7 way2 evicted");
    look(mk(2, 5), 1'b1, 11, "R7 touched way kept");
    look(mk(6, 5), 1'b1, 9, "R7 second fill");
    look(mk(5, 5), 1'b1, 8, "R7 way0 kept");
  endtask

  task automatic t_conflict;
    step(1'b0, '0, 1'b1, mk(20, 9), 4, 1'b1, mk(21, 9), 2);
    look(mk(21, 9), 1'b1, 2, "R9 same set hint applied");
    look(mk(20, 9), 1'b0, 0, "R9 same set invalidate dropped");
    step(1'b0, '0, 1'b1, mk(22, 9), 1, 1'b1, mk(22, 9), 8);
    look(mk(22, 9), 1'b1, 8, "R9 same address hint wins");
    step(1'b0, '0, 1'b1, mk(30, 11), 3, 1'b1, mk(31, 12), 13);
    look(mk(30, 11), 1'b1, 3, "R9 other set invalidate applied");
    look(mk(31, 12), 1'b1, 13, "R9 other set hint applied");
  endtask

  task automatic t_same_cycle;
    hint(mk(50, 33), 3);
    step(1'b1, mk(50, 33), 1'b0, '0, 0, 1'b1, mk(50, 33), 9);
    wait_rsp("R10 old value on rewrite", 1'b1, 3);
    look(mk(50, 33), 1'b1, 9, "R10 new value next lookup");
    step(1'b1, mk(51, 34), 1'b1, mk(51, 34), 14, 1'b0, '0, 0);
    wait_rsp("R10 miss before fill", 1'b0, 0);
    look(mk(51, 34), 1'b1, 14, "R10 fill visible later");
  endtask

  initial begin
    #100us;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    t_reset();
    t_latency();
    t_basic();
    t_replace();
    t_conflict();
    t_same_cycle();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule